// File: doc/BRIEF.md
# Pulse Accumulator Counter

This block is an 8-bit accumulator driven by a single external input. It runs in one of two modes. In event mode it adds one for each chosen transition of the input. In gated mode it adds one on every 64th bus clock, but only while the input sits at its active level. It is used to count external pulses, or to measure how long a signal stays asserted, in units of 64 bus clocks.

A single polarity bit serves both modes. In event mode it picks which edge counts. In gated mode it picks which input level stops the count. The input passes through a clock-domain synchronizer before any logic sees it.

Two sticky status flags record events. The wrap flag records a roll-over of the count. The edge flag records each chosen edge of the input. Each flag has its own interrupt enable and its own clear strobe. Software can read the count register at any time and load it through a simple write port.

Top module: `pulse_accum`

## Requirements
- R1: While `acc_en` is 0 the count does not advance and neither flag is set, whatever the input does.
- R2: In event mode (`gate_mode` = 0), `pol` = 0 makes each rising edge of `pin_in` add one, and `pol` = 1 makes each falling edge add one.
- R3: In event mode an input that toggles every bus clock (rate of half the bus clock) has every chosen edge counted.
- R4: In gated mode (`gate_mode` = 1) the count adds one every 64 bus clocks while the synchronized input is at its active level: high when `pol` = 0, low when `pol` = 1. At the other level the count is held.
- R5: `ovf_flag` sets when an increment takes the count from 0xFF to 0x00. It stays set until a cycle with `ovf_clr` high.
- R6: `edge_flag` sets on each chosen edge of the input while enabled, in either mode: rising for `pol` = 0, falling for `pol` = 1. It stays set until `edge_clr`. A set in the same cycle as a clear wins.
- R7: `ovf_irq` equals `ovf_flag` AND `ovf_ie`, and `edge_irq` equals `edge_flag` AND `edge_ie`. Changing an interrupt enable never changes a flag.
- R8: A cycle with `cnt_we` high loads `cnt_wdata` into the count at the next clock edge. A write beats an increment in the same cycle. `cnt_rdata` always shows the count register.
- R9: Reset clears both flags and both requests, and leaves the count value unchanged.
- R10: `pin_in` passes through a two-flop synchronizer. A chosen edge applied between two clock edges changes the count at the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset of flags and synchronizer |
| acc_en | input | 1 | Accumulator enable |
| gate_mode | input | 1 | 0 = event counting, 1 = gated time accumulation |
| pol | input | 1 | Edge select (event mode) or inhibit level select (gated mode) |
| ovf_ie | input | 1 | Wrap interrupt enable |
| edge_ie | input | 1 | Edge interrupt enable |
| pin_in | input | 1 | Asynchronous external input |
| cnt_we | input | 1 | Count register write strobe |
| cnt_wdata | input | 8 | Count register write value |
| cnt_rdata | output | 8 | Count register value |
| ovf_clr | input | 1 | Clear strobe for the wrap flag |
| edge_clr | input | 1 | Clear strobe for the edge flag |
| ovf_flag | output | 1 | Sticky wrap flag |
| edge_flag | output | 1 | Sticky edge flag |
| ovf_irq | output | 1 | Wrap interrupt request |
| edge_irq | output | 1 | Edge interrupt request |

## Verification
The assertions check the following on every cycle:
- A write beats an increment.
- An increment steps the count by exactly one.
- A disabled accumulator holds its count.
- A wrap or a chosen edge leaves the matching flag set.
- A flag moves only through its own set or clear.
- The prescaler never ticks two cycles in a row.

Only the bench scenarios can show the rest. That covers the exact three-edge latency through the synchronizer, counting at the half-clock input rate, and the one-per-64 accumulation over a known input window. It also covers polarity swapping the edge and the inhibit level, and the count surviving reset.

// File: rtl/pa_pkg.sv
package pa_pkg;
   typedef enum logic {
      PA_EVENT = 1'b0,
      PA_GATED = 1'b1
   } pa_mode_e;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic level,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad
         $error("pa_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], d_async};
         prev  <= chain[STAGES-1];
      end
   end

   assign level = chain[STAGES-1];
   assign rise  = level & ~prev;
   assign fall  = ~level & prev;
endmodule

// File: rtl/pa_prescale.sv
module pa_prescale #(
   parameter int DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad
         $error("pa_prescale: DIV must be positive");
      end else if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] phase;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             phase <= '0;
            else if (phase == LAST) phase <= '0;
            else                    phase <= phase + 1'b1;
         end

         assign tick = (phase == LAST);

         // R4: gated clock ticks are isolated single cycles
         a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] count,
   output logic         wrap
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   generate
      if (W < 2) begin : g_bad
         $error("pa_counter: W must be at least 2");
      end
   endgenerate

   // count register deliberately has no reset
   always_ff @(posedge clk) begin
      if (we)       count <= wdata;
      else if (inc) count <= count + 1'b1;
   end

   assign wrap = inc && !we && (count == TOP);

   a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> count == $past(wdata));

   a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !we) |=> count == W'($past(count) + 1'b1));
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
   import pa_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int GATE_DIV    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_en,
   input  logic             gate_mode,
   input  logic             pol,
   input  logic             ovf_ie,
   input  logic             edge_ie,
   input  logic             pin_in,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   output logic [CNT_W-1:0] cnt_rdata,
   input  logic             ovf_clr,
   input  logic             edge_clr,
   output logic             ovf_flag,
   output logic             edge_flag,
   output logic             ovf_irq,
   output logic             edge_irq
);
   logic     s_level, s_rise, s_fall;
   logic     tick, sel_edge, active, inc, wrap;
   pa_mode_e mode;

   assign mode = pa_mode_e'(gate_mode);

   pa_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pin_in),
      .level(s_level), .rise(s_rise), .fall(s_fall)
   );

   pa_prescale #(.DIV(GATE_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   // one polarity bit: counting edge in event mode, inhibit level in gated mode
   assign sel_edge = pol ? s_fall : s_rise;
   assign active   = s_level ^ pol;

   always_comb begin
      inc = 1'b0;
      if (acc_en) begin
         case (mode)
            PA_GATED: inc = tick && active;
            default:  inc = sel_edge;
         endcase
      end
   end

   pa_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc), .we(cnt_we),
      .wdata(cnt_wdata), .count(cnt_rdata), .wrap(wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag  <= 1'b0;
         edge_flag <= 1'b0;
      end else begin
         if (wrap)                    ovf_flag  <= 1'b1;
         else if (ovf_clr)            ovf_flag  <= 1'b0;
         if (acc_en && sel_edge)      edge_flag <= 1'b1;
         else if (edge_clr)           edge_flag <= 1'b0;
      end
   end

   assign ovf_irq  = ovf_flag & ovf_ie;
   assign edge_irq = edge_flag & edge_ie;

   a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ovf_flag);

   a_r6_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && sel_edge) |=> edge_flag);

   a_r1_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_en && !cnt_we) |=> $stable(cnt_rdata));

   a_r7_flag_only_by_set_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap && !ovf_clr) |=> $stable(ovf_flag));

   a_r9_flags_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!ovf_flag && !edge_flag));
endmodule

// File: tb/tb_pulse_accum.sv
`timescale 1ns/1ps
module tb_pulse_accum;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_en = 1'b0, gate_mode = 1'b0, pol = 1'b0;
   logic       ovf_ie = 1'b0, edge_ie = 1'b0, pin_in = 1'b0;
   logic       cnt_we = 1'b0, ovf_clr = 1'b0, edge_clr = 1'b0;
   logic [7:0] cnt_wdata = 8'h00;
   logic [7:0] cnt_rdata;
   logic       ovf_flag, edge_flag, ovf_irq, edge_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      string req;
      int    sel;   // 0 count, 1 ovf_flag, 2 edge_flag, 3 ovf_irq, 4 edge_irq
      int    val;
   } exp_t;
   exp_t q[$];
   event sample_ev;

   always #2.5 clk = ~clk;

   pulse_accum dut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .gate_mode(gate_mode), .pol(pol),
      .ovf_ie(ovf_ie), .edge_ie(edge_ie), .pin_in(pin_in), .cnt_we(cnt_we),
      .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata), .ovf_clr(ovf_clr),
      .edge_clr(edge_clr), .ovf_flag(ovf_flag), .edge_flag(edge_flag),
      .ovf_irq(ovf_irq), .edge_irq(edge_irq)
   );

   function automatic int observe(int sel);
      case (sel)
         0: return int'(cnt_rdata);
         1: return int'(ovf_flag);
         2: return int'(edge_flag);
         3: return int'(ovf_irq);
         default: return int'(edge_irq);
      endcase
   endfunction

   // monitor: pops expectations and compares against the design outputs
   initial begin
      forever begin
         @(sample_ev);
         while (q.size() > 0) begin
            exp_t e;
            int   act;
            e = q.pop_front();
            act = observe(e.sel);
            checks++;
            if (act != e.val) begin
               errors++;
               $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", e.req, e.sel, act, e.val);
            end
         end
      end
   end

   task automatic push(string req, int sel, int val);
      exp_t e;
      e.req = req; e.sel = sel; e.val = val;
      q.push_back(e);
   endtask

   task automatic sample();
      @(negedge clk);
      ->sample_ev;
      wait (q.size() == 0);
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] v);
      @(negedge clk);
      cnt_we = 1'b1; cnt_wdata = v;
      @(negedge clk);
      cnt_we = 1'b0;
   endtask

   task automatic pulses(int n, int hi, int lo);
      for (int i = 0; i < n; i++) begin
         pin_in = 1'b1; cyc(hi);
         pin_in = 1'b0; cyc(lo);
      end
      cyc(4);
   endtask

   task automatic strobe_edge_clr();
      @(negedge clk); edge_clr = 1'b1;
      @(negedge clk); edge_clr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(5);
      // R9: load a count, then reset, count must survive
      rst_n = 1'b1;
      cyc(2);
      wr(8'h5A);
      @(negedge clk); rst_n = 1'b0;
      cyc(3);
      push("R9 flags cleared", 1, 0);
      push("R9 edge flag cleared", 2, 0);
      push("R9 irq low", 3, 0);
      push("R9 count kept through reset", 0, 8'h5A);
      sample();
      rst_n = 1'b1;
      cyc(2);

      // R8: plain write
      wr(8'h10);
      push("R8 write loads count", 0, 8'h10);
      sample();

      // R2 rising edges
      acc_en = 1'b1;
      pulses(3, 4, 4);
      push("R2 rising edges counted", 0, 8'h13);
      push("R6 edge flag set", 2, 1);
      sample();
      strobe_edge_clr();
      push("R6 edge flag cleared", 2, 0);
      sample();

      // R2 falling edges
      pol = 1'b1;
      cyc(2);
      pulses(2, 4, 4);
      push("R2 falling edges counted", 0, 8'h15);
      sample();

      // R3 input toggling every cycle
      pol = 1'b0;
      cyc(2);
      pulses(10, 1, 1);
      push("R3 half-rate edges all counted", 0, 8'h1F);
      sample();

      // R1 disabled
      strobe_edge_clr();
      acc_en = 1'b0;
      pulses(3, 3, 3);
      push("R1 disabled count held", 0, 8'h1F);
      push("R1 disabled no edge flag", 2, 0);
      sample();

      // R5 / R7 wrap and interrupts
      acc_en = 1'b1;
      wr(8'hFE);
      pulses(2, 4, 4);
      push("R5 wrapped to zero", 0, 8'h00);
      push("R5 overflow flag set", 1, 1);
      push("R7 irq masked", 3, 0);
      sample();
      ovf_ie = 1'b1; edge_ie = 1'b1;
      push("R7 ovf irq raised", 3, 1);
      push("R7 edge irq raised", 4, 1);
      sample();
      ovf_ie = 1'b0;
      push("R7 enable does not clear flag", 1, 1);
      push("R7 ovf irq dropped", 3, 0);
      sample();
      @(negedge clk); ovf_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0;
      push("R5 ovf flag cleared", 1, 0);
      sample();
      strobe_edge_clr();
      push("R7 edge irq follows clear", 4, 0);
      sample();
      edge_ie = 1'b0;

      // R10 latency, then R8 write vs increment
      wr(8'h40);
      @(negedge clk); pin_in = 1'b1;
      @(posedge clk); @(posedge clk);
      push("R10 no change after two edges", 0, 8'h40);
      sample();
      push("R10 change at third edge", 0, 8'h41);
      sample();
      pin_in = 1'b0;
      cyc(4);
      wr(8'h30);
      @(negedge clk); pin_in = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); cnt_we = 1'b1; cnt_wdata = 8'h44;
      @(negedge clk); cnt_we = 1'b0;
      push("R8 write beats increment", 0, 8'h44);
      sample();
      pin_in = 1'b0;
      cyc(4);

      // R4 gated, active high
      gate_mode = 1'b1;
      strobe_edge_clr();
      wr(8'h00);
      pin_in = 1'b1; cyc(192);
      pin_in = 1'b0; cyc(10);
      push("R4 gated high window 3 ticks", 0, 8'h03);
      push("R6 edge flag in gated mode", 2, 1);
      sample();

      // R4 gated, pol=1: high inhibits, low counts
      acc_en = 1'b0; pin_in = 1'b1; cyc(4);
      pol = 1'b1;
      wr(8'h00);
      acc_en = 1'b1;
      cyc(192);
      push("R4 gated inhibited at high level", 0, 8'h00);
      sample();
      pin_in = 1'b0; cyc(128);
      pin_in = 1'b1; cyc(10);
      push("R4 gated low window 2 ticks", 0, 8'h02);
      sample();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule